// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic and Logic Unit

This block is the arithmetic and logic unit of a small processor datapath. It is purely combinational. It takes two operands, A and B, and a 3-bit operation code, and drives one result of the same width. It computes a sum, a difference, a bitwise AND, a bitwise XOR, a left shift and a right shift of A, and a copy of B, all at the same time. The operation code only picks which of these values reaches the result port.

For the two shifts, A is the value that moves and the whole unsigned value of B is the distance. A distance equal to or larger than the operand width clears the result. Arithmetic wraps modulo 2^16. The block has no carry, overflow or other status output, and it holds no state.

The operand width is a parameter with a default of 16. The shifter depth follows from the width.

Top module: `alu16_core`

## Requirements
- R1: Code 3'b000 drives `res` with (A + B) mod 2^16.
- R2: Code 3'b001 drives `res` with (A - B) mod 2^16, so 0 - 1 gives 16'hFFFF.
- R3: Code 3'b010 drives `res` with the bitwise AND of A and B.
- R4: Code 3'b011 drives `res` with the bitwise XOR of A and B.
- R5: Code 3'b100 shifts A left by the unsigned value of B and fills with zeros. Any B of 16 or more gives zero, including a B whose only set bits are above bit 3.
- R6: Code 3'b101 shifts A right by the unsigned value of B and fills with zeros, never with copies of bit 15. Any B of 16 or more gives zero.
- R7: Codes 3'b110 and 3'b111 both drive `res` with B, and the value of A has no effect on `res`.
- R8: The block holds no state. `res` follows any change of `op_sel`, A or B with no clock, and changing only `op_sel` between codes gives each operation's result for the same operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code (see R1 to R7) |
| opnd_a | input | 16 | First operand, which is also the value that shifts move |
| opnd_b | input | 16 | Second operand, which is also the shift distance and the copied value |
| res | output | 16 | Selected result |

## Verification
The bench builds the block with its default width of 16, so the derived shifter has four stages. This makes the saturation boundary reachable at distances 15, 16 and 17, and also at a distance such as 16'h0100 whose bits all lie above the stage inputs. Wrap-around at 16'hFFFF + 1 and 0 - 1, and right shifts of 16'h8000, show that no carry leaks out and no sign fill occurs. Randomized operands for every code, together with a sweep of the code over fixed operands, cover the remaining space and the stateless behaviour.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [2:0] {
    OP_ADD      = 3'b000,
    OP_SUB      = 3'b001,
    OP_AND      = 3'b010,
    OP_XOR      = 3'b011,
    OP_SHL      = 3'b100,
    OP_SHR      = 3'b101,
    OP_PASS     = 3'b110,
    OP_PASS_ALT = 3'b111
  } alu_op_e;

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
  parameter int W        = 16,
  parameter bit SUBTRACT = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  logic [W-1:0] b_eff;
  logic         cin;

  generate
    if (SUBTRACT) begin : g_sub
      assign b_eff = ~b;
      assign cin   = 1'b1;
    end else begin : g_add
      assign b_eff = b;
      assign cin   = 1'b0;
    end
  endgenerate

  assign y = a + b_eff + W'(cin);

  // The inverse operation must recover A (R1, R2).
  always_comb begin
    if (SUBTRACT) begin
      p_sub_inverse_r2: assert (W'(y + b) == a)
        else $error("difference plus B does not return A");
    end else begin
      p_add_inverse_r1: assert (W'(y - b) == a)
        else $error("sum minus B does not return A");
    end
  end

endmodule

// File: rtl/alu16_bitwise.sv
module alu16_bitwise #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_y,
  output logic [W-1:0] xor_y
);

  assign and_y = a & b;
  assign xor_y = a ^ b;

  always_comb begin
    p_and_within_r3: assert (((and_y & ~a) | (and_y & ~b)) == '0)
      else $error("AND result has a bit that an operand lacks");
    p_xor_undo_r4: assert ((xor_y ^ b) == a)
      else $error("XOR result does not undo with B");
  end

endmodule

// File: rtl/alu16_shifter.sv
module alu16_shifter #(
  parameter int W    = 16,
  parameter bit LEFT = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] amt,
  output logic [W-1:0] y
);

  localparam int SH_W = $clog2(W);

  logic [W-1:0] stg [SH_W+1];
  logic         too_far;

  assign stg[0] = a;

  generate
    for (genvar i = 0; i < SH_W; i++) begin : g_stage
      localparam int D = 1 << i;
      logic [W-1:0] moved;
      if (LEFT) begin : g_l
        assign moved = {stg[i][W-1-D:0], {D{1'b0}}};
      end else begin : g_r
        assign moved = {{D{1'b0}}, stg[i][W-1:D]};
      end
      assign stg[i+1] = amt[i] ? moved : stg[i];
    end
  endgenerate

  assign too_far = (|amt[W-1:SH_W]) || (amt[SH_W-1:0] >= SH_W'(W - 1) && 32'(amt[SH_W-1:0]) >= W);
  assign y       = too_far ? '0 : stg[SH_W];

  // A distance at or past the width clears the result; a zero distance keeps A (R5, R6).
  always_comb begin
    if (LEFT) begin
      p_far_left_zero_r5: assert (!(32'(amt) >= W) || y == '0)
        else $error("left shift past width not zero");
      p_zero_left_keep_r5: assert (amt != '0 || y == a)
        else $error("left shift by zero changed A");
    end else begin
      p_far_right_zero_r6: assert (!(32'(amt) >= W) || y == '0)
        else $error("right shift past width not zero");
      p_zero_right_keep_r6: assert (amt != '0 || y == a)
        else $error("right shift by zero changed A");
    end
  end

endmodule

// File: rtl/alu16_select.sv
module alu16_select
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] add_y,
  input  logic [W-1:0] sub_y,
  input  logic [W-1:0] and_y,
  input  logic [W-1:0] xor_y,
  input  logic [W-1:0] shl_y,
  input  logic [W-1:0] shr_y,
  input  logic [W-1:0] pass_y,
  output logic [W-1:0] y
);

  always_comb begin
    case (alu_op_e'(op))
      OP_ADD:  y = add_y;
      OP_SUB:  y = sub_y;
      OP_AND:  y = and_y;
      OP_XOR:  y = xor_y;
      OP_SHL:  y = shl_y;
      OP_SHR:  y = shr_y;
      default: y = pass_y;
    endcase
  end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] res
);

  logic [W-1:0] add_y, sub_y, and_y, xor_y, shl_y, shr_y;

  alu16_addsub #(.W(W), .SUBTRACT(1'b0)) u_add (
    .a(opnd_a), .b(opnd_b), .y(add_y)
  );

  alu16_addsub #(.W(W), .SUBTRACT(1'b1)) u_sub (
    .a(opnd_a), .b(opnd_b), .y(sub_y)
  );

  alu16_bitwise #(.W(W)) u_bits (
    .a(opnd_a), .b(opnd_b), .and_y(and_y), .xor_y(xor_y)
  );

  alu16_shifter #(.W(W), .LEFT(1'b1)) u_shl (
    .a(opnd_a), .amt(opnd_b), .y(shl_y)
  );

  alu16_shifter #(.W(W), .LEFT(1'b0)) u_shr (
    .a(opnd_a), .amt(opnd_b), .y(shr_y)
  );

  alu16_select #(.W(W)) u_sel (
    .op(op_sel),
    .add_y(add_y), .sub_y(sub_y), .and_y(and_y), .xor_y(xor_y),
    .shl_y(shl_y), .shr_y(shr_y), .pass_y(opnd_b),
    .y(res)
  );

  // Result at the port against the unit picked by the code (R7, R8).
  always_comb begin
    p_copy_b_r7: assert (op_sel[2:1] != 2'b11 || res == opnd_b)
      else $error("copy codes do not return B");
    p_route_add_r8: assert (op_sel != OP_ADD || res == add_y)
      else $error("add code routed another unit");
    p_route_shr_r8: assert (op_sel != OP_SHR || res == shr_y)
      else $error("right shift code routed another unit");
  end

endmodule

// File: tb/alu16_core_test.sv
module alu16_core_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;
  localparam int NV = 23;

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{3'b000, 16'h0028, 16'h0064, 16'h008C},
    '{3'b000, 16'hFFFF, 16'h0001, 16'h0000},
    '{3'b000, 16'h7FFF, 16'h0001, 16'h8000},
    '{3'b001, 16'h0064, 16'h0028, 16'h003C},
    '{3'b001, 16'h0000, 16'h0001, 16'hFFFF},
    '{3'b001, 16'h1234, 16'h1234, 16'h0000},
    '{3'b010, 16'hF0F0, 16'h3C3C, 16'h3030},
    '{3'b010, 16'hFFFF, 16'hA5A5, 16'hA5A5},
    '{3'b011, 16'hF0F0, 16'h3C3C, 16'hCCCC},
    '{3'b011, 16'h1234, 16'h1234, 16'h0000},
    '{3'b100, 16'h0001, 16'h000F, 16'h8000},
    '{3'b100, 16'h8001, 16'h0001, 16'h0002},
    '{3'b100, 16'h1234, 16'h0010, 16'h0000},
    '{3'b100, 16'hFFFF, 16'h0000, 16'hFFFF},
    '{3'b100, 16'h00FF, 16'h0008, 16'hFF00},
    '{3'b100, 16'h0003, 16'h0100, 16'h0000},
    '{3'b101, 16'h8000, 16'h000F, 16'h0001},
    '{3'b101, 16'h8000, 16'h0001, 16'h4000},
    '{3'b101, 16'hFFFF, 16'h0011, 16'h0000},
    '{3'b101, 16'hFFFF, 16'hFFFF, 16'h0000},
    '{3'b101, 16'hF00F, 16'h0004, 16'h0F00},
    '{3'b110, 16'hDEAD, 16'hBEEF, 16'hBEEF},
    '{3'b111, 16'h1111, 16'h2222, 16'h2222}
  };

  logic        clk = 1'b0;
  logic [2:0]  op_sel = 3'b000;
  logic [15:0] opnd_a = 16'h0000;
  logic [15:0] opnd_b = 16'h0000;
  logic [15:0] res;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  alu16_core #(.W(16)) uut (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .res(res)
  );

  function automatic logic [15:0] model(input logic [2:0] op, input logic [15:0] a,
                                        input logic [15:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a ^ b;
      3'd4: return (b > 16'd15) ? 16'h0000 : (a << b);
      3'd5: return (b > 16'd15) ? 16'h0000 : (a >> b);
      default: return b;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    op_sel = op;
    opnd_a = a;
    opnd_b = b;
    #(CLK_PERIOD / 4);
  endtask

  task automatic check(input string req, input logic [15:0] exp);
    n_chk++;
    if (res !== exp) begin
      n_bad++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h",
               req, op_sel, opnd_a, opnd_b, res, exp);
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // Initial state: all-zero inputs give a zero sum (R1).
    apply(3'b000, 16'h0000, 16'h0000);
    check("R1", 16'h0000);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].a, VECS[i].b);
      check(req_of(VECS[i].op), VECS[i].exp);
    end

    // R7: with a copy code, A has no effect on the result.
    apply(3'b110, 16'h0000, 16'h5A5A);
    check("R7", 16'h5A5A);
    opnd_a = 16'hFFFF;
    #1;
    check("R7", 16'h5A5A);

    // R5, R6: distances around the width boundary.
    for (int d = 14; d < 18; d++) begin
      apply(3'b100, 16'hC003, 16'(d));
      check("R5", model(3'b100, 16'hC003, 16'(d)));
      apply(3'b101, 16'hC003, 16'(d));
      check("R6", model(3'b101, 16'hC003, 16'(d)));
    end

    // R8: change only the code, with no clock edge in between.
    apply(3'b000, 16'h00F3, 16'h0005);
    for (int c = 0; c < 8; c++) begin
      op_sel = 3'(c);
      #1;
      check("R8", model(3'(c), 16'h00F3, 16'h0005));
    end

    // Randomized operands for every code.
    for (int k = 0; k < 800; k++) begin
      logic [2:0]  rop;
      logic [15:0] ra;
      logic [15:0] rb;
      rop = 3'(k % 8);
      ra  = 16'($urandom);
      rb  = (k % 3 == 0) ? 16'($urandom % 20) : 16'($urandom);
      apply(rop, ra, rb);
      check(req_of(rop), model(rop, ra, rb));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule